// File: doc/BRIEF.md
# Pixel Group Packer

This block takes a continuous stream of 12-bit pixel words, one word per clock whenever the shift enable is high, and collects them into groups of 16. Each completed group is a 192-bit parallel word for a wide memory data bus. A holding stage sits between the collecting register and the bus. A finished group waits there for the memory controller while the next group is already shifting in, so the pixel stream never has to pause.

The input side has no ready signal, because the input is never back-pressured. Every clock with the shift enable high takes one word. The output side is a valid/ready stream with these rules:
- Once `grp_valid` is high it stays high until a cycle in which `grp_ready` is also high.
- While it waits, `grp_data` does not change.
- There is one exception to both rules. If the controller is still holding off when a further group completes, the older group is lost. The new group takes its place, `grp_valid` stays high and the sticky `grp_overrun` flag is raised.
- If a group completes in the same cycle that the controller accepts the previous one, no data is lost.

Top module: `pixel_group_packer`

## Requirements
- R1: An active-low synchronous reset clears the word counter, `grp_valid` and `grp_overrun`. The first accepted word after reset is word 0 of a new group, even if a group was partly filled when reset was applied.
- R2: On the clock edge that accepts the 16th word of a group, the whole group moves into the holding stage and `grp_valid` is high from that edge on.
- R3: Word k of a group (k = 0 is the first accepted) appears on `grp_data[12k+11:12k]`.
- R4: While `grp_valid` is high and `grp_ready` is low, `grp_valid` stays high and `grp_data` stays stable, unless a new group completes in that cycle.
- R5: A cycle with `grp_valid` and `grp_ready` both high and no group completing leaves `grp_valid` low after the edge.
- R6: When a group completes while `grp_valid` is high and `grp_ready` is low, `grp_overrun` is set, the new group replaces the held one and `grp_valid` stays high.
- R7: When a group completes in the same cycle that a held group is accepted, the new group is presented with `grp_valid` high and `grp_overrun` is not set.
- R8: Clocks with `in_valid` low take no word and do not advance the word count, whatever `in_data` carries.
- R9: Once set, `grp_overrun` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Shift enable; a word is taken on each edge while it is high |
| in_data | input | 12 | Pixel word |
| grp_valid | output | 1 | Held group is available |
| grp_ready | input | 1 | Memory controller acknowledges the held group |
| grp_data | output | 192 | Held group, word 0 in the low bits |
| grp_overrun | output | 1 | Sticky flag: a held group was replaced before it was accepted |

## Verification
The assertions assume that `grp_ready` is only meaningful while `grp_valid` is high. They also assume that the input gives no guarantee about `in_data` on idle clocks. The stimulus therefore drives all-ones garbage on idle clocks and raises `grp_ready` freely. The sweeps vary the idle gaps between words and the acknowledge delay. They also place the acknowledge both before and exactly on the completing word, which covers the loss case and the no-loss case alike.

// File: rtl/pgp_pkg.sv
package pgp_pkg;
  localparam int unsigned DEF_WORD_W    = 12;
  localparam int unsigned DEF_GROUP_LEN = 16;
endpackage

// File: rtl/pgp_accum.sv
module pgp_accum #(
  parameter int unsigned WORD_W    = pgp_pkg::DEF_WORD_W,
  parameter int unsigned GROUP_LEN = pgp_pkg::DEF_GROUP_LEN
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [WORD_W-1:0]           in_data,
  output logic                        grp_done,
  output logic [WORD_W*GROUP_LEN-1:0] grp_bus
);
  localparam int unsigned CW   = $clog2(GROUP_LEN);
  localparam int unsigned LAST = GROUP_LEN - 1;

  logic [CW-1:0] cnt;

  assign grp_done = in_valid && (cnt == CW'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (grp_done) cnt <= '0;
    else if (in_valid) cnt <= cnt + 1'b1;
  end

  // Slots 0..LAST-1 are stored; the final word is taken straight from the input
  genvar i;
  generate
    for (i = 0; i < int'(LAST); i++) begin : g_slot
      logic [WORD_W-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (in_valid && (cnt == CW'(i))) slot_q <= in_data;
      end
      assign grp_bus[i*WORD_W +: WORD_W] = slot_q;
    end
  endgenerate
  assign grp_bus[LAST*WORD_W +: WORD_W] = in_data;

  // R8: idle clocks leave the word count alone
  p_idle_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt));

  // R2: a completed group restarts the count at slot 0
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> (cnt == '0));
endmodule

// File: rtl/pgp_hold.sv
module pgp_hold #(
  parameter int unsigned BUS_W = pgp_pkg::DEF_WORD_W * pgp_pkg::DEF_GROUP_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] load_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [BUS_W-1:0] out_data,
  output logic             overrun
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      if (out_valid && !out_ready) overrun <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= load_data;
  end

  // R2: a completing group is presented after the edge
  p_load_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);

  // R4: a held group waits unchanged for the acknowledge
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_data)));

  // R5: an accepted group with nothing new behind it is retired
  p_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> !out_valid);

  // R6: replacing an unaccepted group raises the flag
  p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && load) |=> overrun);

  // R7: a group landing on the accepting cycle loses nothing
  p_no_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!overrun && load && (!out_valid || out_ready)) |=> !overrun);

  // R9: the flag is sticky
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: rtl/pixel_group_packer.sv
module pixel_group_packer #(
  parameter int unsigned WORD_W    = pgp_pkg::DEF_WORD_W,
  parameter int unsigned GROUP_LEN = pgp_pkg::DEF_GROUP_LEN
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [WORD_W-1:0]           in_data,
  output logic                        grp_valid,
  input  logic                        grp_ready,
  output logic [WORD_W*GROUP_LEN-1:0] grp_data,
  output logic                        grp_overrun
);
  localparam int unsigned BUS_W = WORD_W * GROUP_LEN;

  logic             done;
  logic [BUS_W-1:0] bus;

  pgp_accum #(.WORD_W(WORD_W), .GROUP_LEN(GROUP_LEN)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .grp_done (done),
    .grp_bus  (bus)
  );

  pgp_hold #(.BUS_W(BUS_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (done),
    .load_data (bus),
    .out_ready (grp_ready),
    .out_valid (grp_valid),
    .out_data  (grp_data),
    .overrun   (grp_overrun)
  );

  // R1: reset leaves no group pending and no flag
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!grp_valid && !grp_overrun));
endmodule

// File: tb/pixel_group_packer_test.sv
module pixel_group_packer_test;
  localparam int W = 12;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic grp_ready = 1'b0;
  logic grp_valid;
  logic [W*N-1:0] grp_data;
  logic grp_overrun;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pixel_group_packer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_data(grp_data),
    .grp_overrun(grp_overrun)
  );

  function automatic logic [W-1:0] word_of(int g, int k);
    return W'((g * N + k) * 97 + 5);
  endfunction

  function automatic logic [W*N-1:0] group_of(int g);
    logic [W*N-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = word_of(g, k);
    return v;
  endfunction

  task automatic check(string req, logic [W*N-1:0] act, logic [W*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: inputs set at negedge, results observed at the following negedge
  task automatic step(logic v, logic [W-1:0] d, logic r);
    in_valid = v; in_data = d; grp_ready = r;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; in_data = '1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; grp_ready = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  // push words 0..upto-1 of group g, with ready held at r
  task automatic push_words(int g, int upto, int gap, logic r);
    for (int k = 0; k < upto; k++) begin
      for (int i = 0; i < (k * gap) % 3; i++) step(1'b0, '1, r);
      step(1'b1, word_of(g, k), r);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 valid after reset", grp_valid, 0);
    check("R1 overrun after reset", grp_overrun, 0);

    // R2 R3 R8: gap sweep with ready always high
    for (int gap = 0; gap < 4; gap++) begin
      for (int g = 0; g < 3; g++) begin
        int gid = gap * 3 + g;
        push_words(gid, N - 1, gap, 1'b1);
        check("R2 not valid before 16th word", grp_valid, 0);
        step(1'b1, word_of(gid, N - 1), 1'b1);
        check("R2 valid after 16th word", grp_valid, 1);
        check("R3 R8 group layout", grp_data, group_of(gid));
        step(1'b0, '1, 1'b1);
        check("R5 retired after accept", grp_valid, 0);
      end
    end
    check("R7 no overrun with prompt accept", grp_overrun, 0);

    // R4 R5: acknowledge delay sweep
    for (int d = 0; d < 5; d++) begin
      push_words(20 + d, N, 1, 1'b0);
      for (int i = 0; i < d; i++) begin
        step(1'b0, '1, 1'b0);
        check("R4 valid held", grp_valid, 1);
        check("R4 data stable", grp_data, group_of(20 + d));
      end
      step(1'b0, '1, 1'b1);
      check("R5 retired after delayed accept", grp_valid, 0);
    end

    // R7: accept on the same cycle the next group completes
    push_words(30, N, 0, 1'b0);
    push_words(31, N - 1, 0, 1'b0);
    check("R4 held through next group", grp_data, group_of(30));
    step(1'b1, word_of(31, N - 1), 1'b1);
    check("R7 new group valid", grp_valid, 1);
    check("R7 new group data", grp_data, group_of(31));
    check("R7 no overrun", grp_overrun, 0);
    step(1'b0, '1, 1'b1);

    // R6 R9: overrun
    push_words(40, N, 2, 1'b0);
    push_words(41, N, 0, 1'b0);
    check("R6 overrun set", grp_overrun, 1);
    check("R6 valid kept", grp_valid, 1);
    check("R6 newer group kept", grp_data, group_of(41));
    step(1'b0, '1, 1'b1);
    check("R5 retired after overrun", grp_valid, 0);
    for (int i = 0; i < 3; i++) step(1'b0, '1, 1'b0);
    check("R9 overrun sticky", grp_overrun, 1);

    // R1: reset mid-group clears flag and counter
    push_words(50, 5, 0, 1'b0);
    do_reset();
    @(negedge clk);
    check("R1 overrun cleared", grp_overrun, 0);
    push_words(51, N, 1, 1'b0);
    check("R1 fresh group valid", grp_valid, 1);
    check("R1 fresh group data", grp_data, group_of(51));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule